// File: doc/BRIEF.md
# Two-Stage Real-Time Clock Prescaler

This block turns a slow real-time input clock into two enables for calendar logic. A coarse divider with a 7-bit factor produces an intermediate tick. A fine divider with a 15-bit factor counts those ticks and produces the calendar tick, nominally once per second. Each stage divides by its programmed factor plus one. With the factors held after a backup-domain reset, a 32768 Hz input gives a 1 Hz calendar tick.

Both factors sit in one configuration register that lives in the backup domain, so a system reset leaves it alone. A write to it counts only when the initialization-mode input is high and a key sequence has opened the write protection. The factors are loaded in two separate writes: the fine factor first, then the coarse one. While initialization mode is high, both counters stay at zero. When the mode ends, they start again from the new factors.

Two status flags are also provided. One shows that a sub-second shift is pending, with the set and done handshakes driven by the neighbouring shift logic. The other shows that the wakeup-timer settings may be changed.

Top module: `rtc_presc_top`

## Requirements
- R1: With coarse factor A, `apre_tick` pulses first in the (A+1)-th cycle after initialization mode ends, or after system reset is released, and every A+1 cycles after that. When A > 0 each pulse lasts one cycle.
- R2: With fine factor S, `spre_tick` pulses only in a cycle where `apre_tick` is high. It fires first in cycle (A+1)*(S+1) after the counters are released. Exactly S+1 `apre_tick` pulses occur up to and including the first `spre_tick`.
- R3: `rd_cfg` returns the coarse factor in bits 22:16 and the fine factor in bits 14:0. Bits 31:23 and bit 15 read as zero.
- R4: A backup-domain reset sets `rd_cfg` to 0x007F00FF (A=127, S=255). A system reset leaves the configuration unchanged.
- R5: A configuration write (`wr_en`=1, `wr_sel`=0) changes nothing unless `init_mode` is high and the protection is open.
- R6: The protection opens after two consecutive key writes (`wr_en`=1, `wr_sel`=1) whose `wr_data[7:0]` are 0xCA and then 0x53. A key write with any other value closes it. Any key write while it is open closes it. The falling edge of `init_mode` also closes it.
- R7: After each entry into initialization mode, the first accepted write loads only S from `wr_data[14:0]`. The second loads only A from `wr_data[22:16]`.
- R8: While `init_mode` is high, neither tick is asserted.
- R9: `shift_pend` goes high the cycle after `shift_req`. It goes low the cycle after `shift_done` when no request arrives with it, and a request wins if both come together. A system reset clears it.
- R10: `wut_wr_ok` is high one cycle after a cycle in which `init_mode` is low and `wut_en` is low, and low otherwise. It goes low the cycle after `init_mode` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Real-time input clock |
| bkp_rst | input | 1 | Backup-domain reset, active high, initializes the configuration |
| sys_rst | input | 1 | System reset, active high, clears counters, lock and flags |
| init_mode | input | 1 | Initialization mode active |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the configuration register, 1 selects the key register |
| wr_data | input | 32 | Write data |
| shift_req | input | 1 | Shift request from the register front end |
| shift_done | input | 1 | Shift completion from the shift logic |
| wut_en | input | 1 | Wakeup timer enable |
| rd_cfg | output | 32 | Configuration register read value |
| apre_tick | output | 1 | Intermediate tick after the coarse divider |
| spre_tick | output | 1 | Calendar tick after the fine divider |
| shift_pend | output | 1 | Shift pending flag |
| wut_wr_ok | output | 1 | Wakeup configuration may be changed |

## Verification
The dividers are run with the factors from the backup reset and with several programmed pairs. These include both factors at zero, each factor at zero with the other non-zero, and two mixed pairs. Checking the first-tick positions and the count of coarse ticks per fine tick separates a divide-by-N error from a divide-by-N+1 error, and also shows whether the two stages are swapped. Write sequences with a missing key, a broken key, a re-lock after opening, a write outside initialization mode and a re-entry into initialization mode show which gate blocks an ignored write. Split writes that carry data in both fields show that each write touches only its own factor.

// File: rtl/rtc_presc_pkg.sv
`timescale 1ns/1ps
package rtc_presc_pkg;
    localparam int A_W     = 7;
    localparam int S_W     = 15;
    localparam int REG_W   = 32;
    localparam int A_LSB   = 16;
    localparam int KEY_W   = 8;
    localparam logic [KEY_W-1:0] KEY_FIRST  = 8'hCA;
    localparam logic [KEY_W-1:0] KEY_SECOND = 8'h53;
    localparam logic [A_W-1:0]   A_DEFAULT  = 7'd127;
    localparam logic [S_W-1:0]   S_DEFAULT  = 15'd255;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [S_W-1:0] s;
    } presc_cfg_t;

    typedef enum logic [1:0] {
        LK_SHUT  = 2'd0,
        LK_HALF  = 2'd1,
        LK_OPEN  = 2'd2
    } lock_state_t;

    function automatic logic [REG_W-1:0] cfg_to_word(input presc_cfg_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[A_LSB +: A_W] = c.a;
        w[S_W-1:0]      = c.s;
        return w;
    endfunction
endpackage

// File: rtl/rtc_wprot.sv
`timescale 1ns/1ps
module rtc_wprot
    import rtc_presc_pkg::*;
(
    input  logic             clk,
    input  logic             sys_rst,
    input  logic             init_mode,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    output logic             unlocked
);
    lock_state_t state_q, state_d;
    logic        init_q;

    always_comb begin
        state_d = state_q;
        if (init_q && !init_mode) begin
            state_d = LK_SHUT;
        end else if (key_wr) begin
            unique case (state_q)
                LK_SHUT: state_d = (key_val == KEY_FIRST)  ? LK_HALF : LK_SHUT;
                LK_HALF: state_d = (key_val == KEY_SECOND) ? LK_OPEN : LK_SHUT;
                default: state_d = LK_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            state_q <= LK_SHUT;
            init_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            init_q  <= init_mode;
        end
    end

    assign unlocked = (state_q == LK_OPEN);
endmodule

// File: rtl/rtc_cfg_reg.sv
`timescale 1ns/1ps
module rtc_cfg_reg
    import rtc_presc_pkg::*;
(
    input  logic             clk,
    input  logic             bkp_rst,
    input  logic             sys_rst,
    input  logic             init_mode,
    input  logic             wr_ok,
    input  logic [REG_W-1:0] wr_data,
    output presc_cfg_t       cfg
);
    presc_cfg_t cfg_q;
    logic       second_q;

    always_ff @(posedge clk) begin
        if (bkp_rst) begin
            cfg_q.a <= A_DEFAULT;
            cfg_q.s <= S_DEFAULT;
        end else if (wr_ok) begin
            if (second_q) cfg_q.a <= wr_data[A_LSB +: A_W];
            else          cfg_q.s <= wr_data[S_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (sys_rst || !init_mode) second_q <= 1'b0;
        else if (wr_ok)            second_q <= ~second_q;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/rtc_div_stage.sv
`timescale 1ns/1ps
module rtc_div_stage #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold,
    input  logic         en,
    input  logic [W-1:0] limit,
    output logic         wrap
);
    logic [W-1:0] cnt_q;
    logic         at_end;

    assign at_end = (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (rst || hold)  cnt_q <= '0;
        else if (en)      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end

    assign wrap = !hold && en && at_end;
endmodule

// File: rtl/rtc_presc_top.sv
`timescale 1ns/1ps
module rtc_presc_top
    import rtc_presc_pkg::*;
(
    input  logic             clk,
    input  logic             bkp_rst,
    input  logic             sys_rst,
    input  logic             init_mode,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             shift_req,
    input  logic             shift_done,
    input  logic             wut_en,
    output logic [REG_W-1:0] rd_cfg,
    output logic             apre_tick,
    output logic             spre_tick,
    output logic             shift_pend,
    output logic             wut_wr_ok
);
    presc_cfg_t cfg;
    logic       unlocked;
    logic       cfg_wr_ok;
    logic       shift_q;
    logic       wut_q;

    rtc_wprot u_wprot (
        .clk       (clk),
        .sys_rst   (sys_rst),
        .init_mode (init_mode),
        .key_wr    (wr_en && wr_sel),
        .key_val   (wr_data[KEY_W-1:0]),
        .unlocked  (unlocked)
    );

    assign cfg_wr_ok = wr_en && !wr_sel && init_mode && unlocked;

    rtc_cfg_reg u_cfg (
        .clk       (clk),
        .bkp_rst   (bkp_rst),
        .sys_rst   (sys_rst),
        .init_mode (init_mode),
        .wr_ok     (cfg_wr_ok),
        .wr_data   (wr_data),
        .cfg       (cfg)
    );

    rtc_div_stage #(.W(A_W)) u_div_a (
        .clk   (clk),
        .rst   (sys_rst),
        .hold  (init_mode),
        .en    (1'b1),
        .limit (cfg.a),
        .wrap  (apre_tick)
    );

    rtc_div_stage #(.W(S_W)) u_div_s (
        .clk   (clk),
        .rst   (sys_rst),
        .hold  (init_mode),
        .en    (apre_tick),
        .limit (cfg.s),
        .wrap  (spre_tick)
    );

    always_ff @(posedge clk) begin
        if (sys_rst) begin
            shift_q <= 1'b0;
            wut_q   <= 1'b0;
        end else begin
            if (shift_req)       shift_q <= 1'b1;
            else if (shift_done) shift_q <= 1'b0;
            wut_q <= !init_mode && !wut_en;
        end
    end

    assign rd_cfg     = cfg_to_word(cfg);
    assign shift_pend = shift_q;
    assign wut_wr_ok  = wut_q;
endmodule

// File: rtl/rtc_presc_chk.sv
`timescale 1ns/1ps
module rtc_presc_chk (
    input logic        clk,
    input logic        bkp_rst,
    input logic        sys_rst,
    input logic        init_mode,
    input logic        shift_req,
    input logic [31:0] rd_cfg,
    input logic        apre_tick,
    input logic        spre_tick,
    input logic        shift_pend,
    input logic        wut_wr_ok
);
    AST_NO_TICK_IN_INIT: assert property (@(posedge clk) disable iff (sys_rst || bkp_rst)
        init_mode |-> (!apre_tick && !spre_tick)); // R8

    AST_SPRE_WITH_APRE: assert property (@(posedge clk) disable iff (sys_rst || bkp_rst)
        spre_tick |-> apre_tick); // R2

    AST_APRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (sys_rst || bkp_rst)
        (apre_tick && rd_cfg[22:16] != 7'd0) |=> !apre_tick); // R1

    AST_CFG_HELD_OUTSIDE_INIT: assert property (@(posedge clk) disable iff (bkp_rst)
        !init_mode |=> $stable(rd_cfg)); // R5

    AST_SHIFT_SETS: assert property (@(posedge clk) disable iff (sys_rst)
        shift_req |=> shift_pend); // R9

    AST_WUT_LOW_AFTER_INIT: assert property (@(posedge clk) disable iff (sys_rst)
        init_mode |=> !wut_wr_ok); // R10
endmodule

bind rtc_presc_top rtc_presc_chk u_chk (
    .clk        (clk),
    .bkp_rst    (bkp_rst),
    .sys_rst    (sys_rst),
    .init_mode  (init_mode),
    .shift_req  (shift_req),
    .rd_cfg     (rd_cfg),
    .apre_tick  (apre_tick),
    .spre_tick  (spre_tick),
    .shift_pend (shift_pend),
    .wut_wr_ok  (wut_wr_ok)
);

// File: tb/sim_rtc_presc_top.sv
`timescale 1ns/1ps
module sim_rtc_presc_top;
    logic        clk = 1'b0;
    logic        bkp_rst, sys_rst, init_mode, wr_en, wr_sel;
    logic [31:0] wr_data;
    logic        shift_req, shift_done, wut_en;
    logic [31:0] rd_cfg;
    logic        apre_tick, spre_tick, shift_pend, wut_wr_ok;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    rtc_presc_top u0 (
        .clk(clk), .bkp_rst(bkp_rst), .sys_rst(sys_rst), .init_mode(init_mode),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .shift_req(shift_req), .shift_done(shift_done), .wut_en(wut_en),
        .rd_cfg(rd_cfg), .apre_tick(apre_tick), .spre_tick(spre_tick),
        .shift_pend(shift_pend), .wut_wr_ok(wut_wr_ok)
    );

    always #5 clk = ~clk;

    // each entry: {A[6:0], S[14:0]}
    localparam logic [21:0] VEC [0:4] = '{
        {7'd0, 15'd0}, {7'd1, 15'd2}, {7'd3, 15'd0}, {7'd0, 15'd4}, {7'd6, 15'd5}
    };

    function automatic logic [31:0] word(input int a, input int s);
        logic [31:0] w;
        w = '0;
        w[22:16] = a[6:0];
        w[14:0]  = s[14:0];
        return w;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic tick_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic unlock();
        wr(1'b1, 32'h0000_00CA);
        wr(1'b1, 32'h0000_0053);
    endtask

    task automatic measure(input int a, input int s, input string tg);
        int first_a = 0, first_s = 0, n_a = 0, lim;
        lim = (a + 1) * (s + 1) + 4;
        for (int k = 1; k <= lim; k++) begin
            #1;
            if (apre_tick && first_s == 0) n_a++;
            if (apre_tick && first_a == 0) first_a = k;
            if (spre_tick && first_s == 0) first_s = k;
            if (first_s != 0) break;
            @(negedge clk);
        end
        check({"R1 first apre ", tg}, first_a, a + 1);
        check({"R2 first spre ", tg}, first_s, (a + 1) * (s + 1));
        check({"R2 apre per spre ", tg}, n_a, s + 1);
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] exp_cfg;
        bkp_rst = 1; sys_rst = 1; init_mode = 0; wr_en = 0; wr_sel = 0;
        wr_data = '0; shift_req = 0; shift_done = 0; wut_en = 1;
        tick_clk(3);
        bkp_rst = 0; sys_rst = 0;
        #1;
        check("R3 R4 reset cfg", rd_cfg, 32'h007F_00FF);
        check("R9 reset shift", shift_pend, 0);
        check("R10 reset wut", wut_wr_ok, 0);
        #1;
        measure(127, 255, "default");

        // divider table
        for (int i = 0; i < 5; i++) begin
            int a, s;
            a = int'(VEC[i][21:15]);
            s = int'(VEC[i][14:0]);
            @(negedge clk);
            init_mode = 1;
            @(negedge clk);
            unlock();
            wr(1'b0, word(0, s));
            wr(1'b0, word(a, 0));
            check("R3 programmed cfg", rd_cfg, word(a, s));
            init_mode = 0;
            measure(a, s, $sformatf("vec%0d", i));
        end

        // R7 split writes
        @(negedge clk);
        init_mode = 1;
        @(negedge clk);
        unlock();
        wr(1'b0, 32'h0055_0033);
        check("R7 first write only S", rd_cfg, word(6, 'h33));
        wr(1'b0, 32'h0022_0044);
        check("R7 second write only A", rd_cfg, word('h22, 'h33));
        exp_cfg = rd_cfg;
        // R8 no ticks in init
        begin
            int seen = 0;
            for (int k = 0; k < 40; k++) begin
                #1; if (apre_tick || spre_tick) seen++;
                @(negedge clk);
            end
            check("R8 ticks during init", seen, 0);
        end
        init_mode = 0;
        @(negedge clk);

        // R5 write outside init with lock open
        unlock();
        wr(1'b0, 32'h0011_0011);
        check("R5 write outside init ignored", rd_cfg, exp_cfg);
        init_mode = 1;
        @(negedge clk);
        wr(1'b0, 32'h0000_0077);
        check("R5 open and init accepts", rd_cfg, word('h22, 'h77));
        init_mode = 0;
        @(negedge clk);
        exp_cfg = rd_cfg;

        // R6 protection
        init_mode = 1;
        @(negedge clk);
        wr(1'b0, 32'h0000_0001);
        check("R6 no key ignored", rd_cfg, exp_cfg);
        wr(1'b1, 32'h0000_00CA);
        wr(1'b1, 32'h0000_0000);
        wr(1'b1, 32'h0000_0053);
        wr(1'b0, 32'h0000_0002);
        check("R6 broken key ignored", rd_cfg, exp_cfg);
        unlock();
        wr(1'b1, 32'h0000_0099);
        wr(1'b0, 32'h0000_0003);
        check("R6 relock by key write", rd_cfg, exp_cfg);
        unlock();
        init_mode = 0;
        @(negedge clk);
        init_mode = 1;
        @(negedge clk);
        wr(1'b0, 32'h0000_0004);
        check("R6 relock on init exit", rd_cfg, exp_cfg);
        unlock();
        wr(1'b0, 32'h0000_0005);
        check("R6 key opens", rd_cfg, word('h22, 5));
        exp_cfg = rd_cfg;

        // R10 wut flag
        wut_en = 0;
        @(negedge clk);
        #1;
        check("R10 low in init", wut_wr_ok, 0);
        @(negedge clk);
        init_mode = 0;
        @(negedge clk);
        #1;
        check("R10 set when disabled", wut_wr_ok, 1);
        @(negedge clk);
        init_mode = 1;
        @(negedge clk);
        #1;
        check("R10 cleared by init", wut_wr_ok, 0);
        @(negedge clk);
        init_mode = 0; wut_en = 1;

        // R9 shift flag
        @(negedge clk);
        shift_req = 1;
        @(negedge clk);
        shift_req = 0;
        #1; check("R9 set", shift_pend, 1);
        @(negedge clk);
        #1; check("R9 hold", shift_pend, 1);
        @(negedge clk);
        shift_req = 1; shift_done = 1;
        @(negedge clk);
        shift_req = 0;
        #1; check("R9 request wins", shift_pend, 1);
        @(negedge clk);
        shift_done = 0;
        #1; check("R9 cleared by done", shift_pend, 0);
        shift_req = 1;
        @(negedge clk);
        shift_req = 0;
        sys_rst = 1;
        @(negedge clk);
        sys_rst = 0;
        #1; check("R9 cleared by sys reset", shift_pend, 0);

        // R4 resets
        check("R4 sys reset keeps cfg", rd_cfg, exp_cfg);
        @(negedge clk);
        bkp_rst = 1;
        @(negedge clk);
        bkp_rst = 0;
        #1; check("R4 backup reset default", rd_cfg, 32'h007F_00FF);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule